// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block receives Ethernet frames as a byte stream and stores each one in the buffer named by the current receive descriptor in a ring held in system memory. It reaches memory through a simple 32-bit word request port with byte enables. For every frame it fetches three descriptor words: a control word holding the ownership flag, a size word holding the end-of-ring flag, and the buffer address. It then packs the incoming bytes little-endian into words and writes them to the buffer. If the frame is accepted, it writes a completion control word back to the descriptor and moves the ring pointer forward.

Each stored frame is classified from its destination address as unicast, multicast or broadcast. The engine keeps running totals of stored frames, multicast frames, broadcast frames and stored bytes. Its outcomes are reported as one-cycle event pulses. Short frames and frames that find no owned descriptor are reported and otherwise discarded. Software loads the ring base with a write strobe, and a receive enable bit gates the start of each frame.

Top module: `rxq_store_engine`

## Requirements
- R1: While `rx_enable` is low, a waiting frame is not started: `in_ready` stays 0 and no memory request is issued. Once a frame has started, it runs to its end.
- R2: A frame of fewer than 12 bytes is a runt. The descriptor is not rewritten, the ring pointer does not move and the counters do not change. `ev_rx_done` and `ev_normal` pulse. This applies whatever the ownership flag says.
- R3: If bit 31 of descriptor word 0 is 0, the descriptor is not owned. No memory write is made, the pointer does not move and the counters do not change. `ev_buf_unavail` and `ev_abnormal` pulse.
- R4: Frame byte i goes to byte address buffer+i, in byte lane i mod 4 of a little-endian 32-bit word. The buffer address is descriptor word 2 and is word-aligned. The last word of the frame enables only the lanes that hold frame bytes.
- R5: On acceptance, descriptor word 0 becomes ((length+4) << 16) | 0x300. This clears ownership and sets the first and last flags. Descriptor words 1 and 2 are left unchanged.
- R6: If bit 15 of descriptor word 1 is 1, the pointer reloads from the ring base after an accepted frame. Otherwise it advances by 32 bytes. A pulse on `ring_base_wr` loads both the base and the pointer.
- R7: An accepted frame is broadcast when its first six bytes are all 0xFF, unicast when bit 0 of its first byte is 0, and multicast otherwise. `cnt_frames` counts every accepted frame, `cnt_mcast` counts multicast frames and `cnt_bcast` counts broadcast frames.
- R8: `cnt_bytes` grows by length+4 for each accepted frame.
- R9: An accepted frame pulses `ev_rx_done` and `ev_normal` for one cycle. A frame never pulses both `ev_rx_done` and `ev_buf_unavail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable from the control register |
| ring_base_wr | input | 1 | Strobe that loads the ring base and the pointer |
| ring_base | input | ADDR_W | Ring base byte address |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ev_rx_done | output | 1 | Receive-done event pulse |
| ev_normal | output | 1 | Normal-summary event pulse |
| ev_buf_unavail | output | 1 | Buffer-unavailable event pulse |
| ev_abnormal | output | 1 | Abnormal-summary event pulse |
| cnt_frames | output | FRAMES_W | Accepted frames |
| cnt_mcast | output | FRAMES_W | Accepted multicast frames |
| cnt_bcast | output | FRAMES_W | Accepted broadcast frames |
| cnt_bytes | output | BYTES_W | Accepted bytes including 4 per frame |

## Verification
The storing path is swept over every frame length from 12 to 19 bytes, which covers each final-word lane count twice, with and without grant stalls. Each length is tried with four destination patterns: unicast, multicast, full broadcast, and five 0xFF bytes followed by 0xFE. The last pattern separates the six-byte broadcast test from a shorter match. Lengths of 11 and 12 bound the runt rule. A runt on an unowned descriptor shows which of the two drops takes priority. The descriptor at the end of the ring and a reload of the base show where the next fetch lands after each outcome.

// File: rtl/rxq_pkg.sv
// Shared constants and types for the receive descriptor write-back engine.
package rxq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_STREAM, ST_STORE, ST_DECIDE, ST_WRBACK
    } rxq_state_t;

    typedef enum logic [1:0] {
        FR_UNICAST, FR_MULTICAST, FR_BROADCAST
    } frame_kind_t;

    localparam int          DESC_BYTES    = 32;       // descriptor stride in bytes
    localparam int          DESC_RD_WORDS = 3;        // control, sizes, buffer address
    localparam int          RUNT_LIMIT    = 12;       // shortest frame that is stored
    localparam int          CRC_BYTES     = 4;        // added to the reported length
    localparam int          OWN_BIT       = 31;       // ownership in descriptor word 0
    localparam int          WRAP_BIT      = 15;       // end of ring in descriptor word 1
    localparam int          BCAST_SPAN    = 6;        // address bytes for broadcast
    localparam logic [15:0] CTL_FLAGS     = 16'h0300; // first and last segment flags
endpackage

// File: rtl/rxq_ring_ptr.sv
// Ring pointer for the receive descriptor list.
// Holds the ring base and the current descriptor address. A load sets both.
// On an advance, the pointer steps one descriptor forward or, at the end of
// the ring, returns to the base. Assumes load and advance come from
// independent sources; load wins.
module rxq_ring_ptr
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    logic [ADDR_W-1:0] base_q;

    // Purpose: keep the base and move the current pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr    <= '0;
        end else if (base_load) begin
            base_q <= base_in;
            ptr    <= base_in;
        end else if (advance) begin
            ptr <= wrap ? base_q : ptr + STEP;
        end
    end

    a_r6_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !base_load) |=> (ptr == base_q));
    a_r6_load_sets_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        base_load |=> (ptr == $past(base_in)));
endmodule

// File: rtl/rxq_classifier.sv
// Destination classifier.
// Watches every byte taken from the stream and reports whether the frame is
// unicast, multicast or broadcast. The index input is the position of the
// byte being taken and the length input is the number of bytes taken so far.
// Cleared at the start of each frame.
module rxq_classifier
    import rxq_pkg::*;
#(
    parameter int LEN_W = 14
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [LEN_W-1:0] frame_len,
    output frame_kind_t      kind
);
    localparam logic [LEN_W-1:0] SPAN = LEN_W'(BCAST_SPAN);

    logic group_bit;
    logic all_ones;

    // Purpose: record the group bit of byte 0 and whether the address is all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            group_bit <= 1'b0;
            all_ones  <= 1'b1;
        end else if (take) begin
            if (idx == '0)
                group_bit <= data[0];
            if (idx < SPAN && data != 8'hFF)
                all_ones <= 1'b0;
        end
    end

    // Purpose: turn the recorded flags into a frame kind.
    always_comb begin
        if (all_ones && frame_len >= SPAN)
            kind = FR_BROADCAST;
        else if (group_bit)
            kind = FR_MULTICAST;
        else
            kind = FR_UNICAST;
    end

    a_r7_bcast_has_group_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == FR_BROADCAST) |-> group_bit);
endmodule

// File: rtl/rxq_packer.sv
// Byte-to-word packer.
// Places stream bytes into the lanes of a 32-bit little-endian word. It
// reports the word as full after four bytes or after the last byte of a
// frame, and the lane enables then mark the valid bytes. Assumes the caller
// never offers a byte while the word is full, and that each frame starts
// on lane 0 (clear at frame start).
module rxq_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        take,
    input  logic [7:0]  data,
    input  logic        last,
    input  logic        drain,
    output logic [31:0] word,
    output logic [3:0]  be,
    output logic        full
);
    logic [1:0] lane;

    // Purpose: fill lanes, flag a complete word, empty it when written.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lane <= '0;
            word <= '0;
            be   <= '0;
            full <= 1'b0;
        end else if (drain) begin
            be   <= '0;
            full <= 1'b0;
        end else if (take) begin
            word[8*lane +: 8] <= data;
            be[lane]          <= 1'b1;
            lane              <= lane + 2'd1;
            if (lane == 2'd3 || last)
                full <= 1'b1;
        end
    end

    a_r4_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !full);
    a_r4_lanes_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (be == 4'b0001 || be == 4'b0011 || be == 4'b0111 || be == 4'b1111));
endmodule

// File: rtl/rxq_stats.sv
// Receive statistics.
// On each accepted frame, counts the frame, counts multicast and broadcast
// frames by kind, and adds length plus the CRC allowance to the byte total.
// Counters wrap at their width.
module rxq_stats
    import rxq_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int FRAMES_W = 16,
    parameter int BYTES_W  = 24
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  frame_kind_t         kind,
    input  logic [LEN_W-1:0]    frame_len,
    output logic [FRAMES_W-1:0] cnt_frames,
    output logic [FRAMES_W-1:0] cnt_mcast,
    output logic [FRAMES_W-1:0] cnt_bcast,
    output logic [BYTES_W-1:0]  cnt_bytes
);
    localparam logic [FRAMES_W-1:0] ONE = FRAMES_W'(1);

    // Purpose: update the totals when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_frames <= '0;
            cnt_mcast  <= '0;
            cnt_bcast  <= '0;
            cnt_bytes  <= '0;
        end else if (commit) begin
            cnt_frames <= cnt_frames + ONE;
            if (kind == FR_MULTICAST)
                cnt_mcast <= cnt_mcast + ONE;
            if (kind == FR_BROADCAST)
                cnt_bcast <= cnt_bcast + ONE;
            cnt_bytes <= cnt_bytes + BYTES_W'(frame_len) + BYTES_W'(CRC_BYTES);
        end
    end

    a_r7_frames_step: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt_frames == $past(cnt_frames) + ONE));
    a_r8_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cnt_bytes));
endmodule

// File: rtl/rxq_store_engine.sv
// Receive descriptor write-back engine (top).
// For each frame: fetches three descriptor words at the ring pointer, streams
// the bytes into the buffer (if owned), then decides the outcome. A runt or
// an unowned descriptor is dropped with its own events; otherwise the control
// word is written back, the pointer moves and the statistics update.
// Assumes: one memory request is in flight at a time, read data returns in
// order on mem_rvalid, buffer addresses are word-aligned, and frames fit in
// LEN_W bits.
module rxq_store_engine
    import rxq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 14,
    parameter int FRAMES_W = 16,
    parameter int BYTES_W  = 24
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_enable,
    input  logic                ring_base_wr,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    output logic                in_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata,
    output logic [3:0]          mem_be,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [31:0]         mem_rdata,
    output logic                ev_rx_done,
    output logic                ev_normal,
    output logic                ev_buf_unavail,
    output logic                ev_abnormal,
    output logic [FRAMES_W-1:0] cnt_frames,
    output logic [FRAMES_W-1:0] cnt_mcast,
    output logic [FRAMES_W-1:0] cnt_bcast,
    output logic [BYTES_W-1:0]  cnt_bytes
);
    localparam logic [LEN_W-1:0]  MIN_LEN   = LEN_W'(RUNT_LIMIT);
    localparam logic [LEN_W-1:0]  CRC_ADD   = LEN_W'(CRC_BYTES);
    localparam logic [1:0]        LAST_RD   = 2'(DESC_RD_WORDS - 1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    rxq_state_t        state;
    logic [1:0]        rd_idx;
    logic              desc_own;
    logic              desc_wrap;
    logic              last_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [LEN_W-1:0]  frame_len;
    logic [ADDR_W-1:0] ring_ptr;
    logic              frame_start;
    logic              take;
    logic              commit;
    logic              pk_full;
    logic [31:0]       pk_word;
    logic [3:0]        pk_be;
    logic [31:0]       wb_word;
    frame_kind_t       kind;

    assign frame_start = (state == ST_IDLE) && in_valid && rx_enable;
    assign in_ready    = (state == ST_STREAM) && !pk_full && !last_q;
    assign take        = in_ready && in_valid;
    assign commit      = (state == ST_WRBACK) && mem_gnt;

    // Purpose: form the completion control word from the frame length.
    always_comb begin
        wb_word               = '0;
        wb_word[15:0]         = CTL_FLAGS;
        wb_word[16 +: LEN_W]  = frame_len + CRC_ADD;
    end

    // Purpose: drive the single memory request port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ring_ptr;
        mem_wdata = wb_word;
        mem_be    = 4'hF;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ring_ptr + ADDR_W'({rd_idx, 2'b00});
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr;
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_WRBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Purpose: sequence fetch, stream, decision and write-back; pulse events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            rd_idx         <= '0;
            desc_own       <= 1'b0;
            desc_wrap      <= 1'b0;
            last_q         <= 1'b0;
            wr_addr        <= '0;
            frame_len      <= '0;
            ev_rx_done     <= 1'b0;
            ev_normal      <= 1'b0;
            ev_buf_unavail <= 1'b0;
            ev_abnormal    <= 1'b0;
        end else begin
            ev_rx_done     <= 1'b0;
            ev_normal      <= 1'b0;
            ev_buf_unavail <= 1'b0;
            ev_abnormal    <= 1'b0;
            if (take) begin
                frame_len <= frame_len + LEN_W'(1);
                if (in_last)
                    last_q <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        rd_idx    <= '0;
                        last_q    <= 1'b0;
                        frame_len <= '0;
                        state     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_gnt)
                        state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        unique case (rd_idx)
                            2'd0:    desc_own  <= mem_rdata[OWN_BIT];
                            2'd1:    desc_wrap <= mem_rdata[WRAP_BIT];
                            default: wr_addr   <= mem_rdata[ADDR_W-1:0];
                        endcase
                        if (rd_idx == LAST_RD) begin
                            state <= ST_STREAM;
                        end else begin
                            rd_idx <= rd_idx + 2'd1;
                            state  <= ST_FETCH;
                        end
                    end
                end
                ST_STREAM: begin
                    if (pk_full)
                        state <= ST_STORE;
                    else if (last_q && !desc_own)
                        state <= ST_DECIDE;
                end
                ST_STORE: begin
                    if (mem_gnt) begin
                        wr_addr <= wr_addr + WORD_STEP;
                        state   <= last_q ? ST_DECIDE : ST_STREAM;
                    end
                end
                ST_DECIDE: begin
                    if (frame_len < MIN_LEN) begin
                        ev_rx_done <= 1'b1;
                        ev_normal  <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (!desc_own) begin
                        ev_buf_unavail <= 1'b1;
                        ev_abnormal    <= 1'b1;
                        state          <= ST_IDLE;
                    end else begin
                        state <= ST_WRBACK;
                    end
                end
                ST_WRBACK: begin
                    if (mem_gnt) begin
                        ev_rx_done <= 1'b1;
                        ev_normal  <= 1'b1;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    rxq_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_load (ring_base_wr),
        .base_in   (ring_base),
        .advance   (commit),
        .wrap      (desc_wrap),
        .ptr       (ring_ptr)
    );

    rxq_classifier #(.LEN_W(LEN_W)) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .take      (take),
        .idx       (frame_len),
        .data      (in_data),
        .frame_len (frame_len),
        .kind      (kind)
    );

    rxq_packer u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frame_start),
        .take  (take && desc_own),
        .data  (in_data),
        .last  (in_last),
        .drain ((state == ST_STORE) && mem_gnt),
        .word  (pk_word),
        .be    (pk_be),
        .full  (pk_full)
    );

    rxq_stats #(.LEN_W(LEN_W), .FRAMES_W(FRAMES_W), .BYTES_W(BYTES_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .kind       (kind),
        .frame_len  (frame_len),
        .cnt_frames (cnt_frames),
        .cnt_mcast  (cnt_mcast),
        .cnt_bcast  (cnt_bcast),
        .cnt_bytes  (cnt_bytes)
    );

    a_r1_refuse_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_enable) |=> (state == ST_IDLE));
    a_r2_no_commit_on_runt: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (frame_len >= MIN_LEN));
    a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_rx_done, ev_buf_unavail}));
    a_r9_done_with_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |-> ev_normal);
    a_r3_unavail_with_abnormal: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf_unavail |-> ev_abnormal);
endmodule

// File: tb/rxq_store_engine_test.sv
module rxq_store_engine_test;
    localparam int MEM_WORDS = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_enable;
    logic        ring_base_wr;
    logic [31:0] ring_base;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic        in_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_gnt;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        ev_rx_done, ev_normal, ev_buf_unavail, ev_abnormal;
    logic [15:0] cnt_frames, cnt_mcast, cnt_bcast;
    logic [23:0] cnt_bytes;

    always #4 clk = ~clk;   // 125 MHz

    rxq_store_engine uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .ring_base_wr(ring_base_wr), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ev_rx_done(ev_rx_done), .ev_normal(ev_normal),
        .ev_buf_unavail(ev_buf_unavail), .ev_abnormal(ev_abnormal),
        .cnt_frames(cnt_frames), .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast),
        .cnt_bytes(cnt_bytes)
    );

    // Memory model with optional grant stalls.
    logic [31:0] mem [MEM_WORDS];
    logic        stall_en;
    int unsigned cyc = 0;
    int          n_req = 0, n_wr = 0;
    int          n_done = 0, n_norm = 0, n_nobuf = 0, n_abn = 0;
    logic [31:0] last_ctl_rd = 32'hFFFF_FFFF;

    assign mem_gnt = mem_req && !(stall_en && cyc[1:0] == 2'b11);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req && mem_gnt) begin
            n_req <= n_req + 1;
            if (mem_we) begin
                n_wr <= n_wr + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[11:2]];
                if (mem_addr[4:0] == 5'd0) last_ctl_rd <= mem_addr;
            end
        end
        if (ev_rx_done)     n_done  <= n_done + 1;
        if (ev_normal)      n_norm  <= n_norm + 1;
        if (ev_buf_unavail) n_nobuf <= n_nobuf + 1;
        if (ev_abnormal)    n_abn   <= n_abn + 1;
    end

    int n_checks = 0, n_err = 0;
    logic [31:0] exp_ptr = 0;
    logic [15:0] exp_frames = 0, exp_mcast = 0, exp_bcast = 0;
    logic [23:0] exp_bytes = 0;

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // kind: 0 unicast, 1 multicast, 2 broadcast, 3 five 0xFF then 0xFE (multicast)
    function automatic logic [7:0] gen_byte(input int kind, input int seed, input int i);
        if ((kind == 2 && i < 6) || (kind == 3 && i < 5)) return 8'hFF;
        if (kind == 3 && i == 5) return 8'hFE;
        if (i == 0) return (kind == 1) ? 8'h33 : 8'h02;
        return 8'(seed * 13 + i * 7 + 1);
    endfunction

    task automatic send_frame(input int len, input int kind, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = gen_byte(kind, seed, i);
            in_last  = (i == len - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_case(input int len, input int kind, input bit own,
                            input bit stall, input int seed, input bit hold);
        int          di    = int'(exp_ptr) / 32;
        logic [31:0] baddr = 32'h400 + 32'(di) * 32'h100;
        logic [31:0] w0    = {own, 31'h0000_1234};
        logic [31:0] w1    = {16'h0, (di == 3), 15'h0800};
        int d_done, d_norm, d_nobuf, d_abn, d_wr, mism;
        logic [7:0] got_b;
        mem[di*8 + 0] = w0;
        mem[di*8 + 1] = w1;
        mem[di*8 + 2] = baddr;
        for (int w = 0; w < 64; w++) mem[baddr/4 + w] = 32'hA5A5_A5A5;
        d_done = n_done; d_norm = n_norm; d_nobuf = n_nobuf; d_abn = n_abn; d_wr = n_wr;
        stall_en = stall;
        if (hold) begin
            rx_enable = 1'b0;
            fork
                send_frame(len, kind, seed);
                begin
                    int req0 = n_req;
                    repeat (20) @(negedge clk);
                    check("R1", "in_ready while disabled", in_ready, 0);
                    check("R1", "requests while disabled", n_req - req0, 0);
                    rx_enable = 1'b1;
                end
            join
        end else begin
            send_frame(len, kind, seed);
        end
        repeat (12) @(negedge clk);
        check("R6", "descriptor fetch address", last_ctl_rd, exp_ptr);
        if (len < 12) begin
            check("R2", "runt done events", n_done - d_done, 1);
            check("R2", "runt normal events", n_norm - d_norm, 1);
            check("R2", "runt unavail events", n_nobuf - d_nobuf, 0);
            check("R2", "runt ctl word kept", mem[di*8], w0);
        end else if (!own) begin
            check("R3", "unavail events", n_nobuf - d_nobuf, 1);
            check("R3", "abnormal events", n_abn - d_abn, 1);
            check("R3", "done events", n_done - d_done, 0);
            check("R3", "memory writes", n_wr - d_wr, 0);
            check("R3", "ctl word kept", mem[di*8], w0);
        end else begin
            mism = 0;
            for (int i = 0; i < len; i++) begin
                got_b = mem[(baddr + 32'(i)) / 4][8*(i%4) +: 8];
                if (got_b !== gen_byte(kind, seed, i)) mism++;
            end
            check("R4", $sformatf("buffer bytes len=%0d kind=%0d", len, kind), mism, 0);
            check("R4", "byte after frame untouched",
                  mem[(baddr + 32'(len)) / 4][8*(len%4) +: 8], 8'hA5);
            check("R5", "ctl word", mem[di*8], (32'(len + 4) << 16) | 32'h300);
            check("R5", "size word kept", mem[di*8 + 1], w1);
            check("R5", "buffer word kept", mem[di*8 + 2], baddr);
            check("R9", "done events", n_done - d_done, 1);
            check("R9", "normal events", n_norm - d_norm, 1);
            check("R9", "unavail events", n_nobuf - d_nobuf, 0);
            exp_frames++;
            if (kind == 1 || kind == 3) exp_mcast++;
            if (kind == 2) exp_bcast++;
            exp_bytes += 24'(len + 4);
            exp_ptr = (di == 3) ? 32'h0 : exp_ptr + 32;
        end
        check("R7", "frame count", cnt_frames, exp_frames);
        check("R7", "multicast count", cnt_mcast, exp_mcast);
        check("R7", "broadcast count", cnt_bcast, exp_bcast);
        check("R8", "byte count", cnt_bytes, exp_bytes);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_enable = 1'b0; ring_base_wr = 1'b0; ring_base = '0;
        in_valid = 1'b0; in_data = '0; in_last = 1'b0; stall_en = 1'b0;
        for (int w = 0; w < MEM_WORDS; w++) mem[w] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset in_ready", in_ready, 0);
        check("R9", "reset events", {ev_rx_done, ev_normal, ev_buf_unavail, ev_abnormal}, 0);
        check("R7", "reset frame count", cnt_frames, 0);
        check("R8", "reset byte count", cnt_bytes, 0);
        check("R1", "reset mem_req", mem_req, 0);

        // R6: load the ring base
        ring_base = 32'h0; ring_base_wr = 1'b1;
        @(negedge clk);
        ring_base_wr = 1'b0;
        rx_enable = 1'b1;

        // R1: frame waits while disabled, then completes
        run_case(16, 0, 1'b1, 1'b0, 1, 1'b1);

        // R4 R5 R7 R8: sweep of lengths and destination kinds, with and without stalls
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++)
                for (int len = 12; len < 20; len++)
                    run_case(len, k, 1'b1, s[0], len + k, 1'b0);

        // R2: runt boundary and runt priority over ownership
        run_case(11, 0, 1'b1, 1'b0, 3, 1'b0);
        run_case(5, 2, 1'b0, 1'b1, 4, 1'b0);
        run_case(1, 1, 1'b1, 1'b0, 5, 1'b0);
        run_case(12, 2, 1'b1, 1'b0, 6, 1'b0);

        // R3: unowned descriptor, then the same descriptor owned
        run_case(20, 0, 1'b0, 1'b0, 7, 1'b0);
        run_case(40, 1, 1'b1, 1'b1, 8, 1'b0);

        // R6: reload the base mid-ring
        if (exp_ptr == 32'h0) run_case(13, 0, 1'b1, 1'b0, 9, 1'b0);
        @(negedge clk);
        ring_base = 32'h0; ring_base_wr = 1'b1;
        @(negedge clk);
        ring_base_wr = 1'b0;
        exp_ptr = 32'h0;
        run_case(64, 2, 1'b1, 1'b1, 10, 1'b0);
        run_case(23, 3, 1'b1, 1'b0, 11, 1'b0);

        report();
        $finish;
    end
endmodule